// File: doc/BRIEF.md
# Synthesizer Post-Divider with Diagnostic Tap Selector

This block is the output side of a clock synthesizer. It divides a fast oscillator clock by a programmable ratio of 1, 2, 4 or 8. A fixed final divide-by-two then produces an output with a 50% duty cycle. Alongside it, a feedback-style counter emits a single-cycle pulse once every M input cycles.

A 3-bit diagnostic select chooses what appears on a low-speed test pin: nothing, the counter pulse, the divided output or a constant. One select code puts the block into bypass. In bypass, a slow external clock replaces the oscillator as the source of both counters. The divided output then follows that clock, and the test pin shows the counter pulse, so board-level debug can run at a known low rate.

Configuration (M value, ratio code and select) is expected to change only while reset is held.

Top module: `synth_postdiv_test`

## Requirements
- R1: While rst_n is low, fout is low and the M pulse is low. After rst_n rises, the first two rising edges of the selected clock change nothing. Counting starts on the third edge.
- R2: The ratio code n_code maps 00 to 1, 01 to 2, 10 to 4 and 11 to 8 (R = 2^n_code). After the k-th counting edge, fout equals floor(k/R) mod 2.
- R3: fout has a period of 2R selected-clock cycles. It is high for exactly R of them. Once it toggles with R of 2 or more, it holds on the next edge.
- R4: Let P = m_val, with m_val of 0 meaning 512. The M pulse is high after counting edge k exactly when k is at least 1 and k is a multiple of P. Each pulse is one clock wide unless P is 1, in which case the pulse stays high.
- R5: With tsel = 000, test_out is held low.
- R6: With tsel = 110, both counters run from bypass_clk and vco_clk has no effect. fout follows R2 on bypass_clk edges, and test_out carries the M pulse of R4.
- R7: With tsel = 001, test_out is the M pulse. With 010, it is fout. With 011, it is constant high.
- R8: With tsel = 100, 101 or 111, test_out is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast oscillator clock, the normal source of the counters |
| bypass_clk | input | 1 | Slow external clock, used when tsel = 110 |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_val | input | 9 | Pulse period of the M counter; 0 means 512 |
| n_code | input | 2 | Post-divide ratio code |
| tsel | input | 3 | Diagnostic select |
| fout | output | 1 | Divided output, 50% duty |
| test_out | output | 1 | Diagnostic tap output |

## Verification
fout and the M pulse come from registers. Each changes on the rising edge of the selected clock at which the count says it should, and this holds from the third edge after reset release onward. test_out is a combinational selection of those registers, so it is due in the same edge as they are. The bench counts edges of whichever clock the select makes active and predicts both outputs from that count. It samples 2 ns after each falling edge of that clock, half a cycle away from any update. In bypass runs the two clocks have unrelated periods, so a wrongly chosen clock shows up as a miscompare at once.

// File: rtl/synth_pd_pkg.sv
package synth_pd_pkg;

  localparam int TSEL_W = 3;

  typedef enum logic [TSEL_W-1:0] {
    TS_QUIET  = 3'b000,
    TS_MTAP   = 3'b001,
    TS_NTAP   = 3'b010,
    TS_HIGH   = 3'b011,
    TS_BYPASS = 3'b110
  } tsel_e;

endpackage

// File: rtl/pd_clk_sel.sv
module pd_clk_sel
  import synth_pd_pkg::*;
(
  input  logic              vco_clk,
  input  logic              bypass_clk,
  input  logic [TSEL_W-1:0] tsel,
  output logic              bypass_on,
  output logic              div_clk
);

  // Source select; tsel is only changed under reset, so no glitch guard
  assign bypass_on = (tsel == TS_BYPASS);
  assign div_clk   = bypass_on ? bypass_clk : vco_clk;

endmodule

// File: rtl/pd_rst_sync.sv
module pd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q = sync_q[STAGES-1];

  // R1: internal reset must be active whenever the pin is low
  a_r1_async_hold: assert property (@(posedge clk) !rst_n |-> !rst_q);

endmodule

// File: rtl/pd_ndiv.sv
module pd_ndiv #(
  parameter int N_STAGES = 3,
  localparam int CODE_W  = $clog2(N_STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic [CODE_W-1:0] n_code,
  output logic              fout
);

  logic [N_STAGES-1:0] tgl_q;
  logic [N_STAGES-1:0] tgl_d;
  logic [N_STAGES:0]   carry;
  logic                flip_en;
  logic                fout_q;
  logic                fout_d;

  assign carry[0] = 1'b1;

  // Chain of toggle stages: stage i flips when all lower stages are high
  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    assign carry[i+1] = carry[i] & tgl_q[i];
    assign tgl_d[i]   = tgl_q[i] ^ carry[i];
  end

  always_comb begin
    flip_en = carry[n_code];
    fout_d  = fout_q ^ flip_en;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tgl_q  <= '0;
      fout_q <= 1'b0;
    end else begin
      tgl_q  <= tgl_d;
      fout_q <= fout_d;
    end
  end

  assign fout = fout_q;

  // R2: ratio 1 flips the output on every edge
  a_r2_ratio1_flip: assert property (@(posedge clk) disable iff (!rst_q)
    (n_code == '0) |=> (fout != $past(fout)));

  // R3: with ratio >= 2 a toggle is always followed by a hold
  a_r3_hold_after_flip: assert property (@(posedge clk) disable iff (!rst_q)
    (n_code != '0 && n_code == $past(n_code) && fout != $past(fout)) |=> $stable(fout));

endmodule

// File: rtl/pd_mcount.sv
module pd_mcount #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst_q,
  input  logic [M_W-1:0] m_val,
  output logic           pulse
);

  localparam logic [M_W-1:0] ONE = M_W'(1);

  logic [M_W-1:0] cnt_q;
  logic [M_W-1:0] cnt_d;
  logic           pulse_q;
  logic           pulse_d;
  logic           at_end;

  // m_val of zero wraps to all ones, giving a period of 2**M_W
  always_comb begin
    at_end  = (cnt_q == (m_val - ONE));
    cnt_d   = at_end ? '0 : (cnt_q + ONE);
    pulse_d = at_end;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  // R4: pulse is a single cycle wide unless the period is one
  a_r4_single_width: assert property (@(posedge clk) disable iff (!rst_q)
    (pulse && m_val != ONE) |=> !pulse);

endmodule

// File: rtl/synth_postdiv_test.sv
module synth_postdiv_test
  import synth_pd_pkg::*;
#(
  parameter int  M_W      = 9,
  parameter int  N_STAGES = 3,
  localparam int N_CODE_W = $clog2(N_STAGES + 1)
) (
  input  logic                vco_clk,
  input  logic                bypass_clk,
  input  logic                rst_n,
  input  logic [M_W-1:0]      m_val,
  input  logic [N_CODE_W-1:0] n_code,
  input  logic [TSEL_W-1:0]   tsel,
  output logic                fout,
  output logic                test_out
);

  logic div_clk;
  logic bypass_on;
  logic rst_q;
  logic m_pulse;
  logic n_out;

  pd_clk_sel u_clk_sel (
    .vco_clk    (vco_clk),
    .bypass_clk (bypass_clk),
    .tsel       (tsel),
    .bypass_on  (bypass_on),
    .div_clk    (div_clk)
  );

  pd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (div_clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  pd_ndiv #(.N_STAGES(N_STAGES)) u_ndiv (
    .clk    (div_clk),
    .rst_q  (rst_q),
    .n_code (n_code),
    .fout   (n_out)
  );

  pd_mcount #(.M_W(M_W)) u_mcount (
    .clk   (div_clk),
    .rst_q (rst_q),
    .m_val (m_val),
    .pulse (m_pulse)
  );

  // Diagnostic selection; bypass shows the counter pulse
  always_comb begin
    case (tsel)
      TS_QUIET:  test_out = 1'b0;
      TS_MTAP:   test_out = m_pulse;
      TS_NTAP:   test_out = n_out;
      TS_HIGH:   test_out = 1'b1;
      TS_BYPASS: test_out = m_pulse;
      default:   test_out = 1'b0;
    endcase
  end

  assign fout = n_out;

  // R5: quiet select keeps the test pin static
  a_r5_quiet_static: assert property (@(posedge div_clk) disable iff (!rst_q)
    (tsel == TS_QUIET && $past(tsel) == TS_QUIET) |-> $stable(test_out));

  // R6: in bypass the test pin carries the counter pulse
  a_r6_bypass_tap: assert property (@(posedge div_clk) disable iff (!rst_q)
    (bypass_on && $past(bypass_on) && $past(m_pulse) && m_val != M_W'(1)) |-> !test_out);

endmodule

// File: tb/synth_postdiv_test_bench.sv
module synth_postdiv_test_bench;

  logic       clk = 1'b0;
  logic       byp_clk = 1'b0;
  logic       rst_n;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic [2:0] tsel;
  wire        fout;
  wire        test_out;

  int vectors = 0;
  int miscompares = 0;
  int edges = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;      // 50 MHz oscillator stand-in
  always #13 byp_clk = ~byp_clk;

  // Active source per R6: bypass clock only for select 110
  wire act_clk = (tsel == 3'b110) ? byp_clk : clk;

  synth_postdiv_test u_synth_postdiv_test (
    .vco_clk    (clk),
    .bypass_clk (byp_clk),
    .rst_n      (rst_n),
    .m_val      (m_val),
    .n_code     (n_code),
    .tsel       (tsel),
    .fout       (fout),
    .test_out   (test_out)
  );

  // Reference: count active-clock edges since reset release
  always @(posedge act_clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  always @(negedge act_clk) begin : ref_check
    int    k;
    int    r;
    int    per;
    bit    ef;
    bit    ep;
    bit    et;
    string ftag;
    string ttag;
    #2;
    k   = (edges > 2) ? edges - 2 : 0;       // R1: two edges of latency
    r   = 1 << n_code;                       // R2 ratio map
    per = (m_val == 9'd0) ? 512 : int'(m_val);
    ef  = ((k / r) % 2) == 1;
    ep  = (k >= 1) && ((k % per) == 0);      // R4
    case (tsel)
      3'b000:  begin et = 1'b0; ttag = "R5";    end
      3'b001:  begin et = ep;   ttag = "R4/R7"; end
      3'b010:  begin et = ef;   ttag = "R7";    end
      3'b011:  begin et = 1'b1; ttag = "R7";    end
      3'b110:  begin et = ep;   ttag = "R4/R6"; end
      default: begin et = 1'b0; ttag = "R8";    end
    endcase
    if (!rst_n || edges <= 2) ftag = "R1";
    else if (tsel == 3'b110)  ftag = "R6";
    else                      ftag = "R2/R3";
    vectors++;
    if (fout !== ef) begin
      miscompares++;
      $display("FAIL %s fout: got %b expected %b (tsel=%b n=%0d m=%0d k=%0d)",
               ftag, fout, ef, tsel, n_code, m_val, k);
    end
    vectors++;
    if (test_out !== et) begin
      miscompares++;
      $display("FAIL %s test_out: got %b expected %b (tsel=%b n=%0d m=%0d k=%0d)",
               ttag, test_out, et, tsel, n_code, m_val, k);
    end
  end

  task automatic run_case(input logic [2:0] ts, input logic [1:0] nc,
                          input logic [8:0] mv, input int cyc);
    @(posedge act_clk);
    #1;
    rst_n  = 1'b0;
    tsel   = ts;
    n_code = nc;
    m_val  = mv;
    repeat (4) @(negedge act_clk);
    rst_n = 1'b1;
    repeat (cyc) @(negedge act_clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    rst_n  = 1'b0;
    tsel   = 3'b000;
    n_code = 2'd0;
    m_val  = 9'd1;
    repeat (3) @(negedge clk);
    run_case(3'b000, 2'd0, 9'd5,   40);   // R1 R2 R5
    run_case(3'b001, 2'd1, 9'd5,   60);   // R2 R4 R7
    run_case(3'b001, 2'd2, 9'd1,   50);   // R4 period one
    run_case(3'b001, 2'd3, 9'd0, 1100);   // R4 zero means 512, R3 ratio 8
    run_case(3'b011, 2'd2, 9'd3,   40);   // R7 constant high
    run_case(3'b010, 2'd1, 9'd4,   50);   // R7 divided output on pin
    run_case(3'b010, 2'd3, 9'd7,   70);   // R3 duty at ratio 8
    run_case(3'b100, 2'd0, 9'd3,   30);   // R8
    run_case(3'b101, 2'd1, 9'd3,   30);   // R8
    run_case(3'b111, 2'd2, 9'd3,   30);   // R8
    run_case(3'b110, 2'd0, 9'd3,   60);   // R6 bypass, ratio 1
    run_case(3'b110, 2'd1, 9'd7,   60);   // R6
    run_case(3'b110, 2'd3, 9'd2,   80);   // R6 ratio 8
    run_case(3'b001, 2'd0, 9'd9,   60);   // R2 ratio 1, R4
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule